// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block is the command engine of a DDR SDRAM controller. It accepts one host access at a time, a read or a write of one burst at a flat address. It turns the access into an activate, a column command without auto-precharge, and a precharge that closes every bank. It drives the SDRAM command pins, the bank address and the row/column address. It also raises a data-window strobe so that a separate datapath knows when to move data. Burst length, CAS latency, the row-precharge, activate-to-column and refresh-cycle waits, and the refresh period are all inputs that are sampled at run time. They are not build-time constants.

After reset the sequencer runs the power-up sequence without host involvement. The sequence is a precharge of all banks, two auto-refresh commands and a mode-register load that carries the configured burst length and CAS latency. Only after this does it report ready. An internal interval counter then requests an auto-refresh every programmed number of clocks. A pending refresh is issued from the idle state ahead of any host access.

States: `S_IPRE` (power-up precharge-all), `S_IREF1` and `S_IREF2` (power-up refreshes), `S_IMRS` (mode-register load), `S_IDLE`, `S_REF` (periodic refresh), `S_ACT` (activate), `S_RD` / `S_WR` (column command), `S_DATA` (latency and data beats), `S_PRE` (precharge-all and host acknowledge) and `S_WAIT` (shared timed wait). The transitions are as follows:
- Each command state except `S_RD`/`S_WR` goes to `S_WAIT` with a return state. The return states chain `S_IPRE`→`S_IREF1`→`S_IREF2`→`S_IMRS`→`S_IDLE`, `S_REF`→`S_IDLE`, `S_ACT`→`S_RD` or `S_WR`, and `S_PRE`→`S_IDLE`.
- `S_IDLE` goes to `S_REF` when a refresh is pending. Otherwise it goes to `S_ACT` on a host request.
- `S_RD`/`S_WR` go to `S_DATA`, and `S_DATA` goes to `S_PRE` after the last beat.

Top module: `ddr_cmd_seq`

## Requirements
- R1: Command pins {cs_n,ras_n,cas_n,we_n} use NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, MODE LOAD=0000. After reset the first commands are PRECHARGE, REFRESH, REFRESH and MODE LOAD, spaced max(trp,2), max(trfc,2) and max(trfc,2) cycles. `host_rdy` stays low until 2 cycles after MODE LOAD.
- R2: MODE LOAD drives bank address 0, addr[2:0]=cfg_burst, addr[3]=0 and addr[6:4]=cfg_cas. The burst codes are 1=2 beats, 2=4 and 3=8. The CAS codes are 2=2.0, 3=3.0, 5=1.5 and 6=2.5 clocks.
- R3: A host address is {bank[1:0], row, column} from MSB to LSB. It is captured when `host_req` is high in a cycle where `host_rdy` is high. ACTIVE follows in the next cycle, carrying the bank and the row.
- R4: READ or WRITE comes max(trcd,2) cycles after ACTIVE, with the same bank. Column bits 0..9 go on addr[9:0] and higher column bits go one place up, skipping addr[10]. addr[10] is 0 (no auto-precharge).
- R5: For a read, `dq_win` rises floor(CL) cycles after READ and stays high for burst/2 cycles. `dq_rd` is high with it. `dq_half` is high during the window only for CL 1.5 or 2.5.
- R6: For a write, `dq_win` rises 1 cycle after WRITE and stays high for burst/2 cycles, with `dq_rd` and `dq_half` low.
- R7: PRECHARGE with addr[10]=1 follows in the cycle right after the last window cycle. `host_ack` is high in exactly that cycle, once per request.
- R8: After PRECHARGE the sequencer is idle again after max(trp,2) cycles. If no refresh is pending, `host_rdy` rises in that cycle.
- R9: Once initialisation is done, an idle sequencer issues REFRESH exactly every cfg_refi cycles.
- R10: A pending refresh wins over a host request. `host_rdy` is low while it is pending, REFRESH is issued first, and ACTIVE follows max(trfc,2)+1 cycles after REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst | input | 2 | Burst code (1/2/3 = 2/4/8 beats) |
| cfg_cas | input | 3 | CAS latency code (2,3,5,6) |
| cfg_trp | input | TW | Precharge wait in clocks |
| cfg_trcd | input | TW | Activate-to-column wait in clocks |
| cfg_trfc | input | TW | Refresh-cycle wait in clocks |
| cfg_refi | input | REFI_W | Refresh period in clocks |
| host_req | input | 1 | Host access request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W+2 | Flat address {bank,row,column} |
| host_rdy | output | 1 | Request will be accepted this cycle |
| host_ack | output | 1 | One-cycle completion pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ROW_W | Row/column/mode address |
| dq_win | output | 1 | Data transfer window |
| dq_half | output | 1 | Read window is shifted by half a clock |
| dq_rd | output | 1 | Window belongs to a read |

## Verification
A refresh coming due and a host request can land in the same idle cycle. The bench provokes this on purpose: it takes the cycle of one idle refresh, waits exactly one refresh period less a cycle, and raises a request in the cycle where the pending flag appears. It then expects `host_rdy` low, a REFRESH before the ACTIVE, and ACTIVE exactly max(trfc,2)+1 cycles after the REFRESH. Random accesses with a short refresh period also make the two meet by chance, and the same spacing check is applied whenever a REFRESH shows up ahead of an ACTIVE.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    typedef enum logic [3:0] {
        S_IPRE, S_IREF1, S_IREF2, S_IMRS,
        S_IDLE, S_REF, S_ACT, S_RD, S_WR,
        S_DATA, S_PRE, S_WAIT
    } seq_state_t;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_t;

    // beats on the bus = clock cycles of data window times two
    function automatic logic [3:0] win_cycles(input logic [1:0] code);
        case (code)
            2'd2:    return 4'd2;
            2'd3:    return 4'd4;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [1:0] cas_whole(input logic [2:0] code);
        case (code)
            3'd3:    return 2'd3;
            3'd5:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic cas_frac(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd6);
    endfunction

endpackage

// File: rtl/ddr_wait_ctr.sv
module ddr_wait_ctr #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (load_val == '0) ? '0 : load_val - TW'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign count = cnt_q;
    assign done  = (cnt_q <= TW'(1));

    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (!load && cnt_q == '0) |=> (cnt_q == '0)) else $error("wait counter wrapped"); // R8

endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] period,
    input  logic          take,
    output logic          pend
);
    logic [PW-1:0] tick_q;
    logic          pend_q;
    logic          expire;

    assign expire = en && (({1'b0, tick_q} + (PW+1)'(1)) >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (expire)
                tick_q <= '0;
            else if (en)
                tick_q <= tick_q + PW'(1);
            if (expire)
                pend_q <= 1'b1;
            else if (take)
                pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pend_q && !take) |=> pend_q) else $error("refresh request lost"); // R9

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int TW      = 6,
    parameter int REFI_W  = 12,
    parameter int MRD_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_burst,
    input  logic [2:0]               cfg_cas,
    input  logic [TW-1:0]            cfg_trp,
    input  logic [TW-1:0]            cfg_trcd,
    input  logic [TW-1:0]            cfg_trfc,
    input  logic [REFI_W-1:0]        cfg_refi,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [ROW_W+COL_W+1:0]   host_addr,
    output logic                     host_rdy,
    output logic                     host_ack,
    output logic                     sd_cs_n,
    output logic                     sd_ras_n,
    output logic                     sd_cas_n,
    output logic                     sd_we_n,
    output logic [1:0]               sd_ba,
    output logic [ROW_W-1:0]         sd_addr,
    output logic                     dq_win,
    output logic                     dq_half,
    output logic                     dq_rd
);
    localparam int AP_BIT = 10;
    localparam int BANK_LSB = ROW_W + COL_W;

    seq_state_t state_q, state_d;
    seq_state_t ret_q, ret_d;
    logic              init_done_q;
    logic              cap_we_q;
    logic [1:0]        cap_bank_q;
    logic [ROW_W-1:0]  cap_row_q;
    logic [COL_W-1:0]  cap_col_q;
    logic              ld;
    logic [TW-1:0]     ld_val;
    logic [TW-1:0]     wcount;
    logic              wdone;
    logic              ref_pend;
    logic              accept;
    logic [TW-1:0]     beats_tw;
    sd_cmd_t           cmd;
    logic [ROW_W-1:0]  col_addr;

    assign beats_tw = TW'(win_cycles(cfg_burst));
    assign accept   = (state_q == S_IDLE) && !ref_pend && host_req;

    ddr_wait_ctr #(.TW(TW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .count    (wcount),
        .done     (wdone)
    );

    ddr_refresh_timer #(.PW(REFI_W)) u_refi (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (init_done_q),
        .period (cfg_refi),
        .take   (state_q == S_REF),
        .pend   (ref_pend)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        ld      = 1'b0;
        ld_val  = '0;
        unique case (state_q)
            S_IPRE:  begin state_d = S_WAIT; ret_d = S_IREF1; ld = 1'b1; ld_val = cfg_trp;  end
            S_IREF1: begin state_d = S_WAIT; ret_d = S_IREF2; ld = 1'b1; ld_val = cfg_trfc; end
            S_IREF2: begin state_d = S_WAIT; ret_d = S_IMRS;  ld = 1'b1; ld_val = cfg_trfc; end
            S_IMRS:  begin state_d = S_WAIT; ret_d = S_IDLE;  ld = 1'b1; ld_val = TW'(MRD_CYC); end
            S_IDLE: begin
                if (ref_pend)
                    state_d = S_REF;
                else if (host_req)
                    state_d = S_ACT;
            end
            S_REF:   begin state_d = S_WAIT; ret_d = S_IDLE; ld = 1'b1; ld_val = cfg_trfc; end
            S_ACT: begin
                state_d = S_WAIT;
                ret_d   = cap_we_q ? S_WR : S_RD;
                ld      = 1'b1;
                ld_val  = cfg_trcd;
            end
            S_RD: begin
                state_d = S_DATA;
                ld      = 1'b1;
                ld_val  = TW'(cas_whole(cfg_cas)) + beats_tw;
            end
            S_WR: begin
                state_d = S_DATA;
                ld      = 1'b1;
                ld_val  = TW'(1) + beats_tw;
            end
            S_DATA:  if (wdone) state_d = S_PRE;
            S_PRE:   begin state_d = S_WAIT; ret_d = S_IDLE; ld = 1'b1; ld_val = cfg_trp; end
            S_WAIT:  if (wdone) state_d = ret_q;
            default: state_d = S_IPRE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IPRE;
            ret_q   <= S_IPRE;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    // request capture and initialisation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_done_q <= 1'b0;
            cap_we_q    <= 1'b0;
            cap_bank_q  <= '0;
            cap_row_q   <= '0;
            cap_col_q   <= '0;
        end else begin
            if (state_q == S_IMRS)
                init_done_q <= 1'b1;
            if (accept) begin
                cap_we_q   <= host_we;
                cap_bank_q <= host_addr[BANK_LSB +: 2];
                cap_row_q  <= host_addr[COL_W +: ROW_W];
                cap_col_q  <= host_addr[COL_W-1:0];
            end
        end
    end

    // column bits placed around the auto-precharge bit
    always_comb begin
        col_addr = '0;
        for (int i = 0; i < COL_W; i++) begin
            if (i < AP_BIT)
                col_addr[i] = cap_col_q[i];
            else
                col_addr[i+1] = cap_col_q[i];
        end
    end

    // output decode
    always_comb begin
        cmd     = CMD_NOP;
        sd_ba   = 2'b00;
        sd_addr = '0;
        unique case (state_q)
            S_IPRE, S_PRE: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            S_IREF1, S_IREF2, S_REF: cmd = CMD_REF;
            S_IMRS: begin
                cmd          = CMD_LMR;
                sd_addr[2:0] = {1'b0, cfg_burst};
                sd_addr[6:4] = cfg_cas;
            end
            S_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = cap_bank_q;
                sd_addr = cap_row_q;
            end
            S_RD, S_WR: begin
                cmd     = (state_q == S_RD) ? CMD_RD : CMD_WR;
                sd_ba   = cap_bank_q;
                sd_addr = col_addr;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign dq_win   = (state_q == S_DATA) && (wcount <= beats_tw);
    assign dq_rd    = dq_win && !cap_we_q;
    assign dq_half  = dq_rd && cas_frac(cfg_cas);
    assign host_ack = (state_q == S_PRE);
    assign host_rdy = (state_q == S_IDLE) && !ref_pend;

    AST_RDY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n) !init_done_q |-> !host_rdy) else $error("ready during init"); // R1
    AST_COL_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_RD || state_q == S_WR) |-> ($past(state_q) == S_WAIT)) else $error("column without activate wait"); // R4
    AST_ACK_AFTER_WIN:  assert property (@(posedge clk) disable iff (!rst_n) host_ack |-> $past(dq_win)) else $error("ack not after last beat"); // R7
    AST_REF_FIRST:      assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_IDLE && ref_pend) |=> (state_q == S_REF)) else $error("refresh not served first"); // R10

endmodule

// File: tb/ddr_cmd_seq_tb.sv
`timescale 1ns/1ps
module ddr_cmd_seq_tb;
    localparam int ROW_W = 13;
    localparam int COL_W = 10;
    localparam int TW = 6;
    localparam int REFI_W = 12;
    localparam int AW = ROW_W + COL_W + 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic [1:0] cfg_burst = 2'd1;
    logic [2:0] cfg_cas = 3'd2;
    logic [TW-1:0] cfg_trp = 6'd3, cfg_trcd = 6'd2, cfg_trfc = 6'd5;
    logic [REFI_W-1:0] cfg_refi = 12'd100;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic host_rdy, host_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic dq_win, dq_half, dq_rd;

    ddr_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .REFI_W(REFI_W), .MRD_CYC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_cas(cfg_cas),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_trfc(cfg_trfc), .cfg_refi(cfg_refi),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_rdy(host_rdy), .host_ack(host_ack),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .dq_win(dq_win), .dq_half(dq_half), .dq_rd(dq_rd)
    );

    localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;

    logic [3:0]       lcmd [64];
    int               lcyc [64];
    logic [1:0]       lba  [64];
    logic [ROW_W-1:0] laddr[64];
    int n_log = 0;
    int win_first = 0, win_cnt = 0, ack_cnt = 0, ack_cyc = 0;
    bit win_half = 1'b0, win_rd = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != C_NOP && n_log < 64) begin
                lcmd[n_log]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
                lcyc[n_log]  = cyc;
                lba[n_log]   = sd_ba;
                laddr[n_log] = sd_addr;
                n_log++;
            end
            if (dq_win) begin
                if (win_cnt == 0) win_first = cyc;
                win_cnt++;
                win_half |= dq_half;
                win_rd   |= dq_rd;
            end
            if (host_ack) begin
                ack_cnt++;
                ack_cyc = cyc;
            end
        end
    end

    function automatic int gap(input int v);
        return (v < 2) ? 2 : v;
    endfunction
    function automatic int beats_of(input int c);
        return (c == 3) ? 4 : (c == 2) ? 2 : 1;
    endfunction
    function automatic int whole_of(input int c);
        return (c == 3) ? 3 : (c == 5) ? 1 : 2;
    endfunction
    function automatic int frac_of(input int c);
        return (c == 5 || c == 6) ? 1 : 0;
    endfunction
    function automatic int colmap(input int col);
        int r = 0;
        for (int i = 0; i < COL_W; i++)
            if (col[i]) r |= (i < 10) ? (1 << i) : (1 << (i + 1));
        return r;
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_log;
        n_log = 0; win_cnt = 0; win_half = 0; win_rd = 0; ack_cnt = 0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        end
    endtask

    task automatic do_access(input bit we, input logic [AW-1:0] a, input bit conflict);
        int r, ai, p, rc, n_pre, seen;
        ai = -1;
        if (!conflict) begin
            seen = 0;
            for (int i = 0; i < 400; i++) begin
                if (host_rdy) begin seen = 1; break; end
                tick;
            end
            chk("R8 ready before access", seen, 1);
            cfg_trp  = TW'($urandom_range(0, 7));
            cfg_trcd = TW'($urandom_range(0, 7));
            cfg_trfc = TW'($urandom_range(0, 7));
            clr_log;
        end else begin
            clr_log;
            for (int i = 0; i < 4 * int'(cfg_refi) && n_log == 0; i++) tick;
            r = lcyc[0];
            while (cyc < r + int'(cfg_refi) - 1) tick;
            chk("R10 rdy low while refresh pending", int'(host_rdy), 0);
        end
        host_req = 1'b1; host_we = we; host_addr = a;
        for (int i = 0; i < 400 && ack_cnt == 0; i++) tick;
        host_req = 1'b0;
        for (int i = 0; i < n_log; i++)
            if (lcmd[i] == C_ACT) begin ai = i; break; end
        chk("R3 activate issued", (ai >= 0) ? 1 : 0, 1);
        if (ai < 0 || ai + 2 >= n_log) return;
        if (conflict) chk("R10 refresh before activate", int'(ai > 0 && lcmd[ai-1] == C_REF), 1);
        if (ai > 0 && lcmd[ai-1] == C_REF)
            chk("R10 refresh to activate spacing", lcyc[ai] - lcyc[ai-1], gap(int'(cfg_trfc)) + 1);
        chk("R3 activate bank", int'(lba[ai]), int'(a[AW-1 -: 2]));
        chk("R3 activate row", int'(laddr[ai]), int'(a[COL_W +: ROW_W]));
        chk("R4 column command", int'(lcmd[ai+1]), we ? int'(C_WR) : int'(C_RD));
        chk("R4 trcd spacing", lcyc[ai+1] - lcyc[ai], gap(int'(cfg_trcd)));
        chk("R4 column bank", int'(lba[ai+1]), int'(a[AW-1 -: 2]));
        chk("R4 column address no AP", int'(laddr[ai+1]), colmap(int'(a[COL_W-1:0])));
        p = ai + 2;
        if (we) begin
            chk("R6 write window start", win_first - lcyc[ai+1], 1);
            chk("R6 write window length", win_cnt, beats_of(int'(cfg_burst)));
            chk("R6 write half flag", int'(win_half), 0);
            chk("R6 write dir flag", int'(win_rd), 0);
        end else begin
            chk("R5 read window start", win_first - lcyc[ai+1], whole_of(int'(cfg_cas)));
            chk("R5 read window length", win_cnt, beats_of(int'(cfg_burst)));
            chk("R5 read half flag", int'(win_half), frac_of(int'(cfg_cas)));
            chk("R5 read dir flag", int'(win_rd), 1);
        end
        chk("R7 precharge command", int'(lcmd[p]), int'(C_PRE));
        chk("R7 precharge A10", int'(laddr[p][10]), 1);
        chk("R7 precharge right after window", lcyc[p], win_first + win_cnt);
        chk("R7 ack in precharge cycle", ack_cyc, lcyc[p]);
        n_pre = n_log;
        rc = -1;
        for (int i = 0; i < 60; i++) begin
            if (host_rdy) begin rc = cyc; break; end
            tick;
        end
        if (n_log == n_pre && n_pre == p + 1)
            chk("R8 idle after trp", rc, lcyc[p] + gap(int'(cfg_trp)));
        chk("R7 single ack", ack_cnt, 1);
    endtask

    task automatic run_phase(input int bl, input int cl, input int refi);
        int rc;
        logic [AW-1:0] a;
        cfg_burst = 2'(bl); cfg_cas = 3'(cl); cfg_refi = REFI_W'(refi);
        cfg_trp = 6'd3; cfg_trcd = 6'd2; cfg_trfc = 6'd5;
        host_req = 1'b0;
        rst_n = 1'b0;
        repeat (3) tick;
        chk("R1 reset rdy low", int'(host_rdy), 0);
        chk("R7 reset ack low", int'(host_ack), 0);
        chk("R5 reset window low", int'(dq_win), 0);
        clr_log;
        rst_n = 1'b1;
        rc = -1;
        for (int i = 0; i < 200; i++) begin
            tick;
            if (host_rdy) begin rc = cyc; break; end
        end
        chk("R1 init command count", int'(n_log >= 4), 1);
        if (n_log >= 4) begin
            chk("R1 init precharge", int'(lcmd[0]), int'(C_PRE));
            chk("R1 init precharge A10", int'(laddr[0][10]), 1);
            chk("R1 init refresh 1", int'(lcmd[1]), int'(C_REF));
            chk("R1 trp gap", lcyc[1] - lcyc[0], gap(3));
            chk("R1 init refresh 2", int'(lcmd[2]), int'(C_REF));
            chk("R1 trfc gap 1", lcyc[2] - lcyc[1], gap(5));
            chk("R1 init mode load", int'(lcmd[3]), int'(C_LMR));
            chk("R1 trfc gap 2", lcyc[3] - lcyc[2], gap(5));
            chk("R2 mode burst field", int'(laddr[3][3:0]), bl);
            chk("R2 mode cas field", int'(laddr[3][6:4]), cl);
            chk("R2 mode bank", int'(lba[3]), 0);
            chk("R1 ready after mode load", rc, lcyc[3] + 2);
        end
        // directed corners: lowest and highest addresses, then random
        do_access(1'b0, '0, 1'b0);
        do_access(1'b1, '1, 1'b0);
        for (int k = 0; k < 10; k++) begin
            a = AW'({$urandom(), $urandom()});
            do_access(1'($urandom_range(0, 1)), a, 1'b0);
        end
        // idle refresh spacing
        for (int i = 0; i < 40 && !host_rdy; i++) tick;
        clr_log;
        repeat (3 * refi + 10) tick;
        chk("R9 refresh count", int'(n_log >= 3), 1);
        if (n_log >= 3) begin
            for (int i = 1; i < 3; i++) begin
                chk("R9 refresh command", int'(lcmd[i]), int'(C_REF));
                chk("R9 refresh period", lcyc[i] - lcyc[i-1], refi);
            end
        end
        // refresh due in the same cycle as a host request
        cfg_trfc = 6'd4;
        do_access(1'b0, AW'(32'h0155_5A5A), 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 150000);
        summary;
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        run_phase(1, 5, 60);
        run_phase(2, 2, 45);
        run_phase(3, 6, 80);
        run_phase(2, 3, 70);
        summary;
        $finish;
    end

endmodule